// File: doc/BRIEF.md
# Multiplexed-Page Attraction Memory Lookup

This block is the lookup and fill path of a node-local memory that is used as a large cache, where several virtual pages are folded onto one physical page frame. Every block slot of a frame remembers which virtual page its contents belong to. An access names a physical frame, a block offset inside the page and a virtual page id. It hits only if that slot holds a valid block whose remembered id equals the requested id.

On a miss in a frame that has been mapped, the block asks the interconnect for the line. It installs the returned data under the new id. Whatever block another virtual page had left at that offset is displaced. A displaced block that is dirty or holds ownership is handed out on an eviction stream so that it is not lost. An access to a frame that has never been mapped is reported as a fault, and no fill is requested. Frame allocation is signalled from outside on a plain control input.

The request, fill-request, fill-return and eviction paths use valid/ready handshakes. A source holds valid and its payload stable until ready is seen in the same cycle. The block accepts one request at a time. The lookup response and the fill-done indication are one-cycle pulses with no back-pressure.

Top module: `mpam_lookup`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, fill_req_valid, fill_done and evict_valid are 0. No frame is mapped.
- R2: An access to an unmapped frame produces resp_valid=1, resp_fault=1 and resp_hit=0 in the cycle after acceptance. No fill request is issued, and a later access to that frame faults again until the frame is allocated.
- R3: alloc_valid, when the block is idle, marks alloc_frame as mapped and empties all of its slots. A later miss in a mapped frame raises fill_req_valid carrying the request's frame, offset and virtual page id, held stable until fill_req_ready.
- R4: An access whose slot is valid with a stored id equal to req_vpid gives resp_hit=1, resp_fault=0 and the stored data on resp_data in the cycle after acceptance. No fill request follows.
- R5: An access at an offset held by a different virtual page id misses (resp_hit=0, resp_fault=0). The fill replaces the slot's id, so the earlier id misses at that offset afterwards.
- R6: A fill writes only the requested slot. Every other offset of the frame keeps missing until it is accessed itself.
- R7: fill_ready is 1 while a fill is awaited. fill_done pulses with fill_done_data in the cycle after fill_valid and fill_ready are both 1, and the installed block hits from the next access on.
- R8: The 2-bit coherence state is 00 shared copy, 01 non-exclusive owner, 10 exclusive owner and 11 dirty. A read fill installs fill_state; any write leaves the slot at 11.
- R9: When a fill displaces a valid slot whose state is not 00, evict_valid rises in the fill_done cycle. It carries the frame, offset, old virtual page id and old data, all held until evict_ready. Displacing an empty slot or a 00 slot raises no eviction.
- R10: req_ready is 0 from acceptance until the access is complete, including any eviction handshake. It is also 0 while alloc_valid is 1, so allocation wins over a request in the same cycle.
- R11: A write hit returns the old data on resp_data, stores req_wdata and marks the slot dirty.
- R12: A write miss installs req_wdata instead of the fill data, as dirty, and fill_done_data equals req_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Map a frame and empty its slots |
| alloc_frame | input | FRAME_W | Frame to map |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted when high with req_valid |
| req_write | input | 1 | Access is a write |
| req_frame | input | FRAME_W | Physical frame of the access |
| req_offset | input | OFF_W | Block offset in the page |
| req_vpid | input | VPID_W | Virtual page id of the access |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Lookup result pulse |
| resp_hit | output | 1 | Lookup hit |
| resp_fault | output | 1 | Frame not mapped |
| resp_data | output | DATA_W | Stored data on a hit |
| fill_req_valid | output | 1 | Line request valid |
| fill_req_ready | input | 1 | Line request taken |
| fill_req_frame | output | FRAME_W | Frame of the requested line |
| fill_req_offset | output | OFF_W | Offset of the requested line |
| fill_req_vpid | output | VPID_W | Virtual page id of the requested line |
| fill_valid | input | 1 | Returned line valid |
| fill_ready | output | 1 | Returned line accepted |
| fill_data | input | DATA_W | Returned line data |
| fill_state | input | 2 | Coherence state granted with the line |
| fill_done | output | 1 | Fill installed pulse |
| fill_done_data | output | DATA_W | Data installed by the fill |
| evict_valid | output | 1 | Displaced block valid |
| evict_ready | input | 1 | Displaced block taken |
| evict_frame | output | FRAME_W | Frame of the displaced block |
| evict_offset | output | OFF_W | Offset of the displaced block |
| evict_vpid | output | VPID_W | Old virtual page id |
| evict_data | output | DATA_W | Old data |

## Verification
The bench builds the block with two frames, 1 KB pages of 128-byte blocks (eight slots per frame), 4-bit virtual page ids and 16-bit data. With eight slots, a sweep can visit every offset of a frame after a re-allocation. That proves only the requested slots were filled. With two frames, one frame can be re-allocated while the other keeps its contents. With the small id width, several virtual pages can collide at one offset, which exercises displacement from each coherence state, including the dirty block left by a write hit and by a write miss.

// File: rtl/mpam_pkg.sv
package mpam_pkg;

  typedef enum logic [1:0] {
    CS_SHARED = 2'b00,
    CS_OWNER  = 2'b01,
    CS_EXCL   = 2'b10,
    CS_DIRTY  = 2'b11
  } coh_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FREQ,
    ST_FWAIT,
    ST_DONE,
    ST_EVICT
  } ctl_t;

  // Any state other than a plain shared copy must survive displacement.
  function automatic logic needs_writeback(coh_t s);
    return s != CS_SHARED;
  endfunction

endpackage

// File: rtl/mpam_slot_store.sv
module mpam_slot_store
  import mpam_pkg::*;
#(
  parameter int FRAMES = 4,
  parameter int SLOTS  = 128,
  parameter int VPID_W = 6,
  parameter int DATA_W = 32,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int OFF_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [FRAME_W-1:0] alloc_frame,
  input  logic [FRAME_W-1:0] rd_frame,
  input  logic [OFF_W-1:0]   rd_offset,
  output logic               rd_mapped,
  output logic               rd_valid,
  output logic [VPID_W-1:0]  rd_vpid,
  output coh_t               rd_state,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [OFF_W-1:0]   wr_offset,
  input  logic [VPID_W-1:0]  wr_vpid,
  input  coh_t               wr_state,
  input  logic [DATA_W-1:0]  wr_data
);

  logic              fr_map  [FRAMES];
  logic              fr_vld  [FRAMES];
  logic [VPID_W-1:0] fr_vpid [FRAMES];
  coh_t              fr_st   [FRAMES];
  logic [DATA_W-1:0] fr_dat  [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic [SLOTS-1:0]  vld_q;
    logic              map_q;
    logic [VPID_W-1:0] vpid_q [SLOTS];
    coh_t              st_q   [SLOTS];
    logic [DATA_W-1:0] dat_q  [SLOTS];
    logic              sel_alloc;
    logic              sel_wr;

    assign sel_alloc = alloc_en && (alloc_frame == FRAME_W'(g));
    assign sel_wr    = wr_en && (wr_frame == FRAME_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        map_q <= 1'b0;
      end else if (sel_alloc) begin
        map_q <= 1'b1;
        vld_q <= '0;
      end else if (sel_wr) begin
        vld_q[wr_offset] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        vpid_q[wr_offset] <= wr_vpid;
        st_q[wr_offset]   <= wr_state;
        dat_q[wr_offset]  <= wr_data;
      end
    end

    assign fr_map[g]  = map_q;
    assign fr_vld[g]  = vld_q[rd_offset];
    assign fr_vpid[g] = vpid_q[rd_offset];
    assign fr_st[g]   = st_q[rd_offset];
    assign fr_dat[g]  = dat_q[rd_offset];
  end

  assign rd_mapped = fr_map[rd_frame];
  assign rd_valid  = fr_vld[rd_frame];
  assign rd_vpid   = fr_vpid[rd_frame];
  assign rd_state  = fr_st[rd_frame];
  assign rd_data   = fr_dat[rd_frame];

  // R3: an allocated frame reads back as mapped with the slot empty
  p_alloc_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !wr_en && alloc_frame == rd_frame) |=>
      ($past(rd_frame) != rd_frame) || (rd_mapped && !rd_valid));

endmodule

// File: rtl/mpam_hit_check.sv
module mpam_hit_check
  import mpam_pkg::*;
#(
  parameter int VPID_W = 6
) (
  input  logic              rd_mapped,
  input  logic              rd_valid,
  input  logic [VPID_W-1:0] rd_vpid,
  input  coh_t              rd_state,
  input  logic [VPID_W-1:0] req_vpid,
  output logic              fault,
  output logic              hit,
  output logic              displace_wb
);

  logic occupied;

  assign occupied    = rd_mapped && rd_valid;
  assign fault       = !rd_mapped;
  assign hit         = occupied && (rd_vpid == req_vpid);
  assign displace_wb = occupied && needs_writeback(rd_state);

endmodule

// File: rtl/mpam_ctrl.sv
module mpam_ctrl
  import mpam_pkg::*;
#(
  parameter int FRAME_W = 2,
  parameter int OFF_W   = 7,
  parameter int VPID_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [VPID_W-1:0]  req_vpid,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_fault,
  output logic [DATA_W-1:0]  resp_data,
  output logic               fill_req_valid,
  input  logic               fill_req_ready,
  output logic [FRAME_W-1:0] fill_req_frame,
  output logic [OFF_W-1:0]   fill_req_offset,
  output logic [VPID_W-1:0]  fill_req_vpid,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic [1:0]         fill_state,
  output logic               fill_done,
  output logic [DATA_W-1:0]  fill_done_data,
  output logic               evict_valid,
  input  logic               evict_ready,
  output logic [FRAME_W-1:0] evict_frame,
  output logic [OFF_W-1:0]   evict_offset,
  output logic [VPID_W-1:0]  evict_vpid,
  output logic [DATA_W-1:0]  evict_data,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [OFF_W-1:0]   rd_offset,
  output logic [VPID_W-1:0]  chk_vpid,
  input  logic               chk_fault,
  input  logic               chk_hit,
  input  logic               chk_wb,
  input  logic [VPID_W-1:0]  rd_vpid,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wr_en,
  output logic [FRAME_W-1:0] wr_frame,
  output logic [OFF_W-1:0]   wr_offset,
  output logic [VPID_W-1:0]  wr_vpid,
  output coh_t               wr_state,
  output logic [DATA_W-1:0]  wr_data
);

  ctl_t               st_q, st_d;
  logic               q_write;
  logic [FRAME_W-1:0] q_frame;
  logic [OFF_W-1:0]   q_offset;
  logic [VPID_W-1:0]  q_vpid;
  logic [DATA_W-1:0]  q_wdata;
  logic [DATA_W-1:0]  done_q;
  logic               ev_pend_q;
  logic [FRAME_W-1:0] ev_frame_q;
  logic [OFF_W-1:0]   ev_off_q;
  logic [VPID_W-1:0]  ev_vpid_q;
  logic [DATA_W-1:0]  ev_data_q;
  logic               accept;
  logic               fill_take;
  logic               ev_take;

  assign req_ready = (st_q == ST_IDLE) && !alloc_valid;
  assign alloc_en  = (st_q == ST_IDLE) && alloc_valid;
  assign accept    = req_valid && req_ready;
  assign fill_take = fill_valid && fill_ready;
  assign ev_take   = evict_valid && evict_ready;

  assign rd_frame  = q_frame;
  assign rd_offset = q_offset;
  assign chk_vpid  = q_vpid;

  assign resp_valid = (st_q == ST_LOOK);
  assign resp_hit   = resp_valid && chk_hit;
  assign resp_fault = resp_valid && chk_fault;
  assign resp_data  = rd_data;

  assign fill_req_valid  = (st_q == ST_FREQ);
  assign fill_req_frame  = q_frame;
  assign fill_req_offset = q_offset;
  assign fill_req_vpid   = q_vpid;
  assign fill_ready      = (st_q == ST_FWAIT);

  assign fill_done      = (st_q == ST_DONE);
  assign fill_done_data = done_q;

  assign evict_valid  = ev_pend_q;
  assign evict_frame  = ev_frame_q;
  assign evict_offset = ev_off_q;
  assign evict_vpid   = ev_vpid_q;
  assign evict_data   = ev_data_q;

  assign wr_frame  = q_frame;
  assign wr_offset = q_offset;
  assign wr_vpid   = q_vpid;

  always_comb begin
    wr_en    = 1'b0;
    wr_state = CS_DIRTY;
    wr_data  = q_wdata;
    if (st_q == ST_LOOK && chk_hit && q_write) begin
      wr_en = 1'b1;
    end else if (fill_take) begin
      wr_en    = 1'b1;
      wr_state = q_write ? CS_DIRTY : coh_t'(fill_state);
      wr_data  = q_write ? q_wdata : fill_data;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_LOOK;
      ST_LOOK:  st_d = (chk_fault || chk_hit) ? ST_IDLE : ST_FREQ;
      ST_FREQ:  if (fill_req_ready) st_d = ST_FWAIT;
      ST_FWAIT: if (fill_valid) st_d = ST_DONE;
      ST_DONE:  st_d = (ev_pend_q && !evict_ready) ? ST_EVICT : ST_IDLE;
      ST_EVICT: if (evict_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ev_pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fill_take) ev_pend_q <= chk_wb;
      else if (ev_take) ev_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q_write  <= req_write;
      q_frame  <= req_frame;
      q_offset <= req_offset;
      q_vpid   <= req_vpid;
      q_wdata  <= req_wdata;
    end
    if (fill_take) begin
      done_q     <= wr_data;
      ev_frame_q <= q_frame;
      ev_off_q   <= q_offset;
      ev_vpid_q  <= rd_vpid;
      ev_data_q  <= rd_data;
    end
  end

  // R4: the lookup answer appears the cycle after acceptance
  p_resp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);

  // R2: a fault never leads to a line request
  p_fault_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |=> !fill_req_valid);

  // R3: a pending line request keeps its payload
  p_fillreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=>
      (fill_req_valid && $stable(fill_req_frame) && $stable(fill_req_offset)
       && $stable(fill_req_vpid)));

  // R7: installation is signalled one cycle after the line is taken
  p_done_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> fill_done);

  // R9: a displaced block is held until taken
  p_evict_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_ready) |=>
      (evict_valid && $stable(evict_vpid) && $stable(evict_data)
       && $stable(evict_offset) && $stable(evict_frame)));

  // R10: no new request while one is in flight
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || fill_req_valid || fill_ready || fill_done || evict_valid) |-> !req_ready);

endmodule

// File: rtl/mpam_lookup.sv
module mpam_lookup
  import mpam_pkg::*;
#(
  parameter int FRAMES      = 4,
  parameter int PAGE_BYTES  = 16384,
  parameter int BLOCK_BYTES = 128,
  parameter int VPID_W      = 6,
  parameter int DATA_W      = 32,
  localparam int SLOTS   = PAGE_BYTES / BLOCK_BYTES,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int OFF_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [FRAME_W-1:0] alloc_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] req_frame,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [VPID_W-1:0]  req_vpid,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_fault,
  output logic [DATA_W-1:0]  resp_data,
  output logic               fill_req_valid,
  input  logic               fill_req_ready,
  output logic [FRAME_W-1:0] fill_req_frame,
  output logic [OFF_W-1:0]   fill_req_offset,
  output logic [VPID_W-1:0]  fill_req_vpid,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic [1:0]         fill_state,
  output logic               fill_done,
  output logic [DATA_W-1:0]  fill_done_data,
  output logic               evict_valid,
  input  logic               evict_ready,
  output logic [FRAME_W-1:0] evict_frame,
  output logic [OFF_W-1:0]   evict_offset,
  output logic [VPID_W-1:0]  evict_vpid,
  output logic [DATA_W-1:0]  evict_data
);

  logic               alloc_en;
  logic [FRAME_W-1:0] rd_frame;
  logic [OFF_W-1:0]   rd_offset;
  logic               rd_mapped, rd_valid;
  logic [VPID_W-1:0]  rd_vpid, chk_vpid;
  coh_t               rd_state;
  logic [DATA_W-1:0]  rd_data;
  logic               chk_fault, chk_hit, chk_wb;
  logic               wr_en;
  logic [FRAME_W-1:0] wr_frame;
  logic [OFF_W-1:0]   wr_offset;
  logic [VPID_W-1:0]  wr_vpid;
  coh_t               wr_state;
  logic [DATA_W-1:0]  wr_data;

  mpam_slot_store #(
    .FRAMES(FRAMES), .SLOTS(SLOTS), .VPID_W(VPID_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_frame(alloc_frame),
    .rd_frame(rd_frame), .rd_offset(rd_offset),
    .rd_mapped(rd_mapped), .rd_valid(rd_valid), .rd_vpid(rd_vpid),
    .rd_state(rd_state), .rd_data(rd_data),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_offset(wr_offset),
    .wr_vpid(wr_vpid), .wr_state(wr_state), .wr_data(wr_data)
  );

  mpam_hit_check #(.VPID_W(VPID_W)) u_check (
    .rd_mapped(rd_mapped), .rd_valid(rd_valid), .rd_vpid(rd_vpid),
    .rd_state(rd_state), .req_vpid(chk_vpid),
    .fault(chk_fault), .hit(chk_hit), .displace_wb(chk_wb)
  );

  mpam_ctrl #(
    .FRAME_W(FRAME_W), .OFF_W(OFF_W), .VPID_W(VPID_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_en(alloc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_frame(req_frame), .req_offset(req_offset), .req_vpid(req_vpid),
    .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_data(resp_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_frame(fill_req_frame), .fill_req_offset(fill_req_offset),
    .fill_req_vpid(fill_req_vpid),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .fill_state(fill_state), .fill_done(fill_done), .fill_done_data(fill_done_data),
    .evict_valid(evict_valid), .evict_ready(evict_ready), .evict_frame(evict_frame),
    .evict_offset(evict_offset), .evict_vpid(evict_vpid), .evict_data(evict_data),
    .rd_frame(rd_frame), .rd_offset(rd_offset), .chk_vpid(chk_vpid),
    .chk_fault(chk_fault), .chk_hit(chk_hit), .chk_wb(chk_wb),
    .rd_vpid(rd_vpid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_offset(wr_offset),
    .wr_vpid(wr_vpid), .wr_state(wr_state), .wr_data(wr_data)
  );

endmodule

// File: tb/mpam_lookup_tb_top.sv
`timescale 1ns/1ps
module mpam_lookup_tb_top;

  localparam int FR_W = 1;
  localparam int OF_W = 3;
  localparam int VP_W = 4;
  localparam int DW   = 16;
  localparam int NVEC = 20;

  typedef struct packed {
    logic            is_alloc;
    logic            wr;
    logic [FR_W-1:0] fr;
    logic [OF_W-1:0] off;
    logic [VP_W-1:0] vpid;
    logic [DW-1:0]   wdata;
    logic [1:0]      fst;
    logic            e_fault;
    logic            e_hit;
    logic [DW-1:0]   e_data;
    logic            e_ev;
    logic [VP_W-1:0] ev_vpid;
    logic [OF_W-1:0] ev_off;
    logic [DW-1:0]   ev_data;
  } vec_t;

  // alloc wr fr off vpid wdata fst | fault hit data | ev ev_vpid ev_off ev_data
  localparam vec_t TBL [0:NVEC-1] = '{
    '{0,0,0,1,3,16'h0000,2'd0, 1,0,16'h0000, 0,0,0,16'h0000}, // R2 unmapped
    '{1,0,0,0,0,16'h0000,2'd0, 0,0,16'h0000, 0,0,0,16'h0000}, // R3 map f0
    '{0,0,0,1,3,16'h0000,2'd0, 0,0,16'hA013, 0,0,0,16'h0000}, // R3 first miss
    '{0,0,0,1,3,16'h0000,2'd0, 0,1,16'hA013, 0,0,0,16'h0000}, // R4 hit
    '{0,0,0,2,3,16'h0000,2'd2, 0,0,16'hA023, 0,0,0,16'h0000}, // R6 other offset
    '{0,0,0,1,5,16'h0000,2'd2, 0,0,16'hA015, 0,0,0,16'h0000}, // R5 shared out
    '{0,0,0,1,3,16'h0000,2'd0, 0,0,16'hA013, 1,5,1,16'hA015}, // R9 excl out
    '{0,1,0,2,3,16'h1234,2'd0, 0,1,16'hA023, 0,0,0,16'h0000}, // R11 write hit
    '{0,0,0,2,3,16'h0000,2'd0, 0,1,16'h1234, 0,0,0,16'h0000}, // R11 readback
    '{0,0,0,2,7,16'h0000,2'd0, 0,0,16'hA027, 1,3,2,16'h1234}, // R8 dirty out
    '{0,1,0,5,2,16'hBEEF,2'd0, 0,0,16'hBEEF, 0,0,0,16'h0000}, // R12 write miss
    '{0,0,0,5,2,16'h0000,2'd0, 0,1,16'hBEEF, 0,0,0,16'h0000}, // R12 readback
    '{0,0,1,0,1,16'h0000,2'd0, 1,0,16'h0000, 0,0,0,16'h0000}, // R2 f1 unmapped
    '{1,0,1,0,0,16'h0000,2'd0, 0,0,16'h0000, 0,0,0,16'h0000}, // R3 map f1
    '{0,0,1,0,1,16'h0000,2'd1, 0,0,16'hB001, 0,0,0,16'h0000}, // R8 owner fill
    '{0,0,0,5,9,16'h0000,2'd0, 0,0,16'hA059, 1,2,5,16'hBEEF}, // R12 dirty out
    '{1,0,0,0,0,16'h0000,2'd0, 0,0,16'h0000, 0,0,0,16'h0000}, // R3 remap f0
    '{0,0,0,1,3,16'h0000,2'd0, 0,0,16'hA013, 0,0,0,16'h0000}, // R3 emptied
    '{0,0,1,0,1,16'h0000,2'd0, 0,1,16'hB001, 0,0,0,16'h0000}, // R3 f1 kept
    '{0,0,1,0,4,16'h0000,2'd0, 0,0,16'hB004, 1,1,0,16'hB001}  // R9 owner out
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            alloc_valid = 1'b0;
  logic [FR_W-1:0] alloc_frame = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [FR_W-1:0] req_frame = '0;
  logic [OF_W-1:0] req_offset = '0;
  logic [VP_W-1:0] req_vpid = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            resp_valid, resp_hit, resp_fault;
  logic [DW-1:0]   resp_data;
  logic            fill_req_valid;
  logic            fill_req_ready = 1'b0;
  logic [FR_W-1:0] fill_req_frame;
  logic [OF_W-1:0] fill_req_offset;
  logic [VP_W-1:0] fill_req_vpid;
  logic            fill_valid = 1'b0;
  logic            fill_ready;
  logic [DW-1:0]   fill_data = '0;
  logic [1:0]      fill_state = '0;
  logic            fill_done;
  logic [DW-1:0]   fill_done_data;
  logic            evict_valid;
  logic            evict_ready = 1'b0;
  logic [FR_W-1:0] evict_frame;
  logic [OF_W-1:0] evict_offset;
  logic [VP_W-1:0] evict_vpid;
  logic [DW-1:0]   evict_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mpam_lookup #(
    .FRAMES(2), .PAGE_BYTES(1024), .BLOCK_BYTES(128), .VPID_W(VP_W), .DATA_W(DW)
  ) dut_i (.*);

  function automatic logic [DW-1:0] line_val(logic [FR_W-1:0] f, logic [OF_W-1:0] o,
                                             logic [VP_W-1:0] v);
    return 16'hA000 | (DW'(f) << 12) | (DW'(o) << 4) | DW'(v);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [FR_W-1:0] f);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_frame = f;
    req_valid   = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R10 alloc wins over request", req_ready, 0);
    @(negedge clk);
    alloc_valid = 1'b0;
    req_valid   = 1'b0;
  endtask

  task automatic do_access(input vec_t v);
    logic [DW-1:0] ld;
    ld = line_val(v.fr, v.off, v.vpid);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = v.wr; req_frame = v.fr;
    req_offset = v.off; req_vpid = v.vpid; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1, "R4 response the cycle after accept", resp_valid, 1);
    chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
    chk(resp_fault == v.e_fault, "R2 fault flag", resp_fault, v.e_fault);
    chk(resp_hit == v.e_hit, "R5 hit flag", resp_hit, v.e_hit);
    if (v.e_hit) chk(resp_data == v.e_data, "R4/R11 hit data", resp_data, v.e_data);
    @(negedge clk);
    if (v.e_fault || v.e_hit) begin
      chk(fill_req_valid == 1'b0, "R2/R4 no line request", fill_req_valid, 0);
      return;
    end
    chk(fill_req_valid == 1'b1, "R3 line request", fill_req_valid, 1);
    chk({fill_req_frame, fill_req_offset, fill_req_vpid} == {v.fr, v.off, v.vpid},
        "R3 line request fields", {fill_req_frame, fill_req_offset, fill_req_vpid},
        {v.fr, v.off, v.vpid});
    @(negedge clk);
    chk(fill_req_valid == 1'b1, "R3 line request held", fill_req_valid, 1);
    fill_req_ready = 1'b1;
    @(negedge clk);
    fill_req_ready = 1'b0;
    chk(fill_ready == 1'b1 && fill_req_valid == 1'b0, "R7 awaiting line",
        {fill_ready, fill_req_valid}, 2'b10);
    fill_valid = 1'b1; fill_data = ld; fill_state = v.fst;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(fill_done == 1'b1, "R7 fill done pulse", fill_done, 1);
    chk(fill_done_data == v.e_data, "R7/R12 installed data", fill_done_data, v.e_data);
    chk(evict_valid == v.e_ev, "R8/R9 eviction raised", evict_valid, v.e_ev);
    if (v.e_ev) begin
      chk({evict_frame, evict_offset, evict_vpid, evict_data} ==
          {v.fr, v.ev_off, v.ev_vpid, v.ev_data}, "R9 eviction fields",
          {evict_frame, evict_offset, evict_vpid, evict_data},
          {v.fr, v.ev_off, v.ev_vpid, v.ev_data});
      @(negedge clk);
      chk(evict_valid == 1'b1 && req_ready == 1'b0, "R9/R10 eviction held",
          {evict_valid, req_ready}, 2'b10);
      evict_ready = 1'b1;
      @(negedge clk);
      evict_ready = 1'b0;
      chk(evict_valid == 1'b0, "R9 eviction taken", evict_valid, 0);
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk({resp_valid, fill_req_valid, fill_done, evict_valid} == 4'b0,
        "R1 outputs idle", {resp_valid, fill_req_valid, fill_done, evict_valid}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i].is_alloc) do_alloc(TBL[i].fr);
      else do_access(TBL[i]);
    end
    // R6 sweep: after remapping frame 0 only offset 1 was filled
    for (int o = 0; o < 8; o++) begin
      vec_t v;
      v = '{0,0,0,OF_W'(o),4'd3,16'h0000,2'd0, 0,(o == 1),
            line_val(1'b0, OF_W'(o), 4'd3), 0,0,0,16'h0000};
      do_access(v);
    end
    // R6 second pass: every offset now hits
    for (int o = 0; o < 8; o++) begin
      vec_t v;
      v = '{0,0,0,OF_W'(o),4'd3,16'h0000,2'd0, 0,1,
            line_val(1'b0, OF_W'(o), 4'd3), 0,0,0,16'h0000};
      do_access(v);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule